// File: doc/BRIEF.md
# Partitioned SIMD Saturating Adder

This block adds two 64-bit packed operands lane by lane. A mode input splits the word into eight 8-bit lanes, four 16-bit lanes, or one 64-bit lane. No carry crosses a lane boundary, so each lane behaves as an independent adder. A saturate control decides whether a lane that overflows wraps or is clamped to its limit. A sign control decides whether the lanes hold unsigned or two's-complement values.

The result is registered in a single pipeline stage. The result comes with a valid flag and a per-lane overflow vector. A producer presents both operands together with a valid strobe. Exactly one clock later the packed sum and the overflow flags can be read.

Top module: `simd_sat_adder`

## Requirements
- R1: `out_valid` equals `in_valid` delayed by one clock. A synchronous reset (`rst_n` low at a rising edge) clears `out_valid`, `sum` and `lane_ovf` to zero.
- R2: The lane size is selected by `lane_sz`: 2'b00 gives 8-bit lanes, 2'b01 gives 16-bit lanes, and 2'b10 or 2'b11 gives one 64-bit lane. Lane i occupies bits [i*LW +: LW]. In wrap mode (`sat_en`=0), each lane of `sum` is the low LW bits of that lane's own a+b, and no carry enters from the lane below.
- R3: In unsigned saturating mode (`sat_en`=1, `signed_en`=0), a lane whose sum carries out of the lane is forced to all ones.
- R4: In signed saturating mode (`sat_en`=1, `signed_en`=1), a lane with positive overflow is forced to 0 followed by all ones (the largest value). A lane with negative overflow is forced to 1 followed by all zeros (the smallest value).
- R5: `lane_ovf[i]` is 1 when lane i overflows. When unsigned, overflow is a carry out of the lane. When signed, overflow means both operands have the same sign and the sign of the sum differs from it. The flag is reported in wrap mode as well as in saturating mode.
- R6: Bits of `lane_ovf` at index equal to or above the active lane count (8, 4 or 1) read zero.
- R7: In 64-bit mode the block is an ordinary full-width adder: the carry runs across all 64 bits, and overflow is reported on `lane_ovf[0]`.
- R8: In a cycle where `in_valid` is low, `sum` and `lane_ovf` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| lane_sz | input | 2 | Lane size: 00 = 8-bit, 01 = 16-bit, 1x = 64-bit |
| sat_en | input | 1 | 1 = saturating, 0 = wrap |
| signed_en | input | 1 | 1 = two's-complement lanes, 0 = unsigned |
| op_a | input | 64 | Packed operand A |
| op_b | input | 64 | Packed operand B |
| out_valid | output | 1 | Result valid, one clock after in_valid |
| sum | output | 64 | Packed lane results |
| lane_ovf | output | 8 | Per-lane overflow flags, index = lane number |

## Verification
There is only one register stage. A wrong captured value therefore shows on `sum` or `lane_ovf` in the cycle right after the operation, and it stays visible until the next valid input replaces it.

The stimulus is chosen to show a carry leaking across a boundary. Some lanes produce a carry out while the lane above them holds values that would visibly change if that carry reached them. Overflow is produced in both directions in every lane size, so a wrong clamp value or a wrong flag also appears on that first cycle.

// File: rtl/simd_sat_adder.sv
module simd_sat_adder #(
  parameter int W = 64
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [1:0]     lane_sz,
  input  logic           sat_en,
  input  logic           signed_en,
  input  logic [W-1:0]   op_a,
  input  logic [W-1:0]   op_b,
  output logic           out_valid,
  output logic [W-1:0]   sum,
  output logic [W/8-1:0] lane_ovf
);
  localparam int NMAX = W / 8;

  logic [W-1:0]    res_k [3];
  logic [NMAX-1:0] ovf_k [3];
  logic [1:0]      sel;

  for (genvar k = 0; k < 3; k++) begin : g_size
    localparam int LW = (k == 0) ? 8 : (k == 1) ? 16 : W;
    localparam int NL = W / LW;
    for (genvar j = 0; j < NMAX; j++) begin : g_lane
      if (j < NL) begin : g_act
        logic [LW-1:0] a, b;
        logic [LW:0]   s;
        logic          ov;
        assign a  = op_a[j*LW +: LW];
        assign b  = op_b[j*LW +: LW];
        assign s  = {1'b0, a} + {1'b0, b};
        assign ov = signed_en ? ((a[LW-1] == b[LW-1]) && (s[LW-1] != a[LW-1])) : s[LW];
        assign ovf_k[k][j] = ov;
        assign res_k[k][j*LW +: LW] = !(sat_en && ov) ? s[LW-1:0] :
                                      signed_en ? {a[LW-1], {(LW-1){~a[LW-1]}}} : {LW{1'b1}};
      end else begin : g_off
        assign ovf_k[k][j] = 1'b0;
      end
    end
  end

  assign sel = lane_sz[1] ? 2'd2 : {1'b0, lane_sz[0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      sum       <= '0;
      lane_ovf  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        sum      <= res_k[sel];
        lane_ovf <= ovf_k[sel];
      end
    end
  end

  a_r1_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r1_valid_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(sum) && $stable(lane_ovf)));
  a_r6_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && lane_sz == 2'b01) |=> (lane_ovf[NMAX-1:W/16] == '0));

  for (genvar i = 0; i < NMAX; i++) begin : g_chk8
    a_r2_lane_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !sat_en && lane_sz == 2'b00) |=>
        (sum[8*i +: 8] == 8'($past(op_a[8*i +: 8]) + $past(op_b[8*i +: 8]))));
    a_r3_uns_clamp: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && sat_en && !signed_en && lane_sz == 2'b00) |=>
        (!lane_ovf[i] || sum[8*i +: 8] == 8'hFF));
  end

  for (genvar i = 0; i < W/16; i++) begin : g_chk16
    a_r4_sgn_clamp: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && sat_en && signed_en && lane_sz == 2'b01) |=>
        (!lane_ovf[i] || sum[16*i +: 16] == 16'h7FFF || sum[16*i +: 16] == 16'h8000));
  end
endmodule

// File: tb/tb_simd_sat_adder.sv
module tb_simd_sat_adder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  lane_sz = 2'b00;
  logic        sat_en = 1'b0;
  logic        signed_en = 1'b0;
  logic [63:0] op_a = '0;
  logic [63:0] op_b = '0;
  logic        out_valid;
  logic [63:0] sum;
  logic [7:0]  lane_ovf;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  simd_sat_adder dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .lane_sz(lane_sz),
    .sat_en(sat_en), .signed_en(signed_en), .op_a(op_a), .op_b(op_b),
    .out_valid(out_valid), .sum(sum), .lane_ovf(lane_ovf)
  );

  // {lane_sz, sat_en, signed_en, a, b, expected sum, expected ovf}
  localparam int NV = 13;
  localparam logic [203:0] TBL [NV] = '{
    {2'b00, 1'b0, 1'b0, 64'h01FF_7F80_0000_FF10, 64'h0101_0180_0000_0120, 64'h0200_8000_0000_0030, 8'h52},
    {2'b00, 1'b0, 1'b1, 64'h01FF_7F80_0000_FF10, 64'h0101_0180_0000_0120, 64'h0200_8000_0000_0030, 8'h30},
    {2'b00, 1'b1, 1'b0, 64'h01FF_7F80_0000_FF10, 64'h0101_0180_0000_0120, 64'h02FF_80FF_0000_FF30, 8'h52},
    {2'b00, 1'b1, 1'b1, 64'h01FF_7F80_0000_FF10, 64'h0101_0180_0000_0120, 64'h0200_7F80_0000_0030, 8'h30},
    {2'b01, 1'b0, 1'b0, 64'hFFFF_7FFF_8000_00FF, 64'h0001_0001_8000_0001, 64'h0000_8000_0000_0100, 8'h0A},
    {2'b01, 1'b1, 1'b1, 64'hFFFF_7FFF_8000_00FF, 64'h0001_0001_8000_0001, 64'h0000_7FFF_8000_0100, 8'h06},
    {2'b01, 1'b1, 1'b0, 64'hFFFF_7FFF_8000_00FF, 64'h0001_0001_8000_0001, 64'hFFFF_8000_FFFF_0100, 8'h0A},
    {2'b10, 1'b0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001, 64'h0000_0000_0000_0000, 8'h01},
    {2'b10, 1'b1, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001, 64'hFFFF_FFFF_FFFF_FFFF, 8'h01},
    {2'b10, 1'b1, 1'b1, 64'h7FFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001, 64'h7FFF_FFFF_FFFF_FFFF, 8'h01},
    {2'b11, 1'b1, 1'b1, 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000, 8'h01},
    {2'b10, 1'b0, 1'b1, 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0001, 64'h0000_0001_0000_0000, 8'h00},
    {2'b00, 1'b1, 1'b1, 64'h0102_0304_0506_0708, 64'h0102_0304_0506_0708, 64'h0204_0608_0A0C_0E10, 8'h00}
  };

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R1 watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset valid", {63'd0, out_valid}, 64'd0);
    check("R1 reset sum", sum, 64'd0);
    check("R1 reset ovf", {56'd0, lane_ovf}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [203:0] v;
      string tg;
      v = TBL[i];
      lane_sz   = v[203:202];
      sat_en    = v[201];
      signed_en = v[200];
      op_a      = v[199:136];
      op_b      = v[135:72];
      in_valid  = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      if (v[203]) tg = "R7 full-width sum";
      else if (!v[201]) tg = "R2 lane wrap sum";
      else if (v[200]) tg = "R4 signed clamp sum";
      else tg = "R3 unsigned clamp sum";
      check(tg, sum, v[71:8]);
      check("R5 lane overflow", {56'd0, lane_ovf}, {56'd0, v[7:0]});
      check("R1 valid after one clock", {63'd0, out_valid}, 64'd1);
      if (v[203:202] == 2'b01)
        check("R6 upper ovf bits zero (16-bit)", {60'd0, lane_ovf[7:4]}, 64'd0);
      if (v[203])
        check("R6 upper ovf bits zero (64-bit)", {57'd0, lane_ovf[7:1]}, 64'd0);
    end

    // R8: new operands without valid leave outputs unchanged
    lane_sz = 2'b00; sat_en = 1'b0; signed_en = 1'b0;
    op_a = 64'h1111_1111_1111_1111; op_b = 64'h2222_2222_2222_2222;
    @(negedge clk);
    check("R1 valid low without strobe", {63'd0, out_valid}, 64'd0);
    check("R8 sum held", sum, 64'h0204_0608_0A0C_0E10);
    check("R8 ovf held", {56'd0, lane_ovf}, 64'd0);

    // R1: latency exactly one clock, then drop
    in_valid = 1'b1;
    #2 check("R1 no early valid", {63'd0, out_valid}, 64'd0);
    @(negedge clk);
    in_valid = 1'b0;
    check("R1 valid rises", {63'd0, out_valid}, 64'd1);
    check("R2 wrap nibble pattern", sum, 64'h3333_3333_3333_3333);
    @(negedge clk);
    check("R1 valid falls", {63'd0, out_valid}, 64'd0);

    // R2/R5: 16-bit lane, carry must cross the byte boundary inside the lane but not the lane edge
    lane_sz = 2'b01; op_a = 64'h00FF_FFFF_00FF_FFFF; op_b = 64'h0001_0001_0001_0001;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R2 16-bit lane isolation", sum, 64'h0100_0000_0100_0000);
    check("R5 16-bit carry flags", {56'd0, lane_ovf}, 64'h05);

    // R1: reset while a result is held
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    check("R1 mid-run reset sum", sum, 64'd0);
    check("R1 mid-run reset ovf", {56'd0, lane_ovf}, 64'd0);
    @(negedge clk);
    finish_run();
  end
endmodule